// File: doc/BRIEF.md
# Post-Increment Load/Store Unit

This unit executes one register-indirect memory access at a time and then advances the base register. An accepted operation reads two registers: the base and the data register. The base value goes out unchanged as the memory address. A word or a halfword then moves between memory and the data register. Once the memory response arrives, the unit writes back the results. The base register receives its old value plus a signed displacement. That displacement is taken from the instruction's immediate bytes, so the pointer can step by any amount, not only by the access size.

The operation comes in as already decoded fields: a valid strobe, the direction, the size, a displacement kind, four immediate bytes and two register indices. The register file exposes two combinational read ports, which the unit addresses straight from the operation fields, and one write port. The memory side is a single-cycle request pulse followed by a response strobe one or more cycles later. Writebacks use the single write port one at a time: the loaded data first, then the updated base. An address that does not match the access size is refused with an error pulse.

Top module: `pinc_lsu`

## Requirements
- R1: For an aligned operation, the address sent with the request equals the base register value read when the operation was accepted, with no displacement added. `mem_we` is 1 for stores and 0 for loads, and `mem_half` is 1 for halfword accesses.
- R2: The value written back to the base register is its old value plus the displacement, modulo 2^32.
- R3: `op_disp_kind` selects the displacement, where `op_imm` byte k is bits [8k+7:8k]. Kind 0 sign-extends byte 0 from bit 7. Kind 1 sign-extends bytes 2..0 (byte 0 least significant) from bit 23. Kinds 2 and 3 use all four bytes as they are.
- R4: A word load writes `mem_rdata` to the data register unchanged. A halfword load writes `mem_rdata[15:0]` zero-extended to 32 bits.
- R5: A store presents the whole data register value on `mem_wdata`. It writes no register except the base.
- R6: A load whose data index equals its base index performs exactly one register write, the loaded value. The base update is dropped.
- R7: No register write occurs before the memory response. The first write comes in the cycle right after `mem_rsp_valid`. When there are two writes, the data write comes first and the base write follows in the next cycle.
- R8: `op_ready` is 1 only while the unit is idle. It drops in the cycle after acceptance and returns in the cycle after the last write.
- R9: A word access with `addr[1:0]` ≠ 0, or a halfword access with `addr[0]` = 1, raises `err_misalign` for one cycle right after acceptance. It issues no memory request and writes no register, and `op_ready` stays 1.
- R10: After reset, `op_ready` is 1 and `mem_req`, `rf_we` and `err_misalign` are 0.
- R11: Each aligned operation raises `mem_req` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Decoded operation present |
| op_ready | output | 1 | Unit idle, operation taken this cycle if valid |
| op_store | input | 1 | 1 = store, 0 = load |
| op_half | input | 1 | 1 = halfword, 0 = word |
| op_disp_kind | input | 2 | Displacement form select (R3) |
| op_imm | input | 32 | Four immediate bytes |
| op_base_idx | input | REG_AW | Base register index |
| op_data_idx | input | REG_AW | Data register index |
| rf_base_raddr | output | REG_AW | Read address for the base register |
| rf_base_rdata | input | 32 | Base register value |
| rf_data_raddr | output | REG_AW | Read address for the data register |
| rf_data_rdata | input | 32 | Data register value |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | REG_AW | Register write index |
| rf_wdata | output | 32 | Register write value |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_half | output | 1 | Request is a halfword |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Store data |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rdata | input | 32 | Load data (halfword in bits 15:0) |
| err_misalign | output | 1 | Misaligned address pulse |

## Verification
Some properties are checked on every cycle. The request is a single-cycle pulse. It always carries an address that suits its size, and it always follows an accepted operation. Nothing happens on memory or the register port while the unit is ready. An error cycle carries neither a request nor a write. The first register write must follow a response. Other behaviour can only be shown by the directed scenarios, which drive the unit and observe its ports. These cover the values: the address equal to the old base, the three displacement forms with their sign handling, the zero-extension of a halfword, the dropped base write when the two indices match, the wrap of the base, and registers left untouched after a refused access.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
    localparam int XLEN      = 32;
    localparam int HALF_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int IMM_BYTES = XLEN / BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ     = 3'd1,
        ST_WAIT    = 3'd2,
        ST_WB_DATA = 3'd3,
        ST_WB_BASE = 3'd4
    } lsu_state_e;

    typedef enum logic [1:0] {
        DISP_S8  = 2'd0,
        DISP_S24 = 2'd1,
        DISP_F32 = 2'd2,
        DISP_F32B = 2'd3
    } disp_kind_e;
endpackage

// File: rtl/pinc_disp_ext.sv
module pinc_disp_ext
    import pinc_pkg::*;
#(
    parameter int SHORT_BYTES = 1,
    parameter int MID_BYTES   = 3
) (
    input  logic [1:0]      kind,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] disp
);
    localparam int SHORT_W = SHORT_BYTES * BYTE_W;
    localparam int MID_W   = MID_BYTES * BYTE_W;

    logic [XLEN-1:0] short_ext;
    logic [XLEN-1:0] mid_ext;

    assign short_ext = {{(XLEN-SHORT_W){imm[SHORT_W-1]}}, imm[SHORT_W-1:0]};
    assign mid_ext   = {{(XLEN-MID_W){imm[MID_W-1]}}, imm[MID_W-1:0]};

    always_comb begin
        case (disp_kind_e'(kind))
            DISP_S8:  disp = short_ext;
            DISP_S24: disp = mid_ext;
            default:  disp = imm;
        endcase
    end
endmodule

// File: rtl/pinc_align_chk.sv
module pinc_align_chk
    import pinc_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic       half,
    output logic       misaligned
);
    always_comb begin
        if (half) misaligned = addr_lo[0];
        else      misaligned = |addr_lo;
    end
endmodule

// File: rtl/pinc_load_fmt.sv
module pinc_load_fmt
    import pinc_pkg::*;
(
    input  logic [XLEN-1:0] raw,
    input  logic            half,
    output logic [XLEN-1:0] value
);
    always_comb begin
        if (half) value = {{(XLEN-HALF_W){1'b0}}, raw[HALF_W-1:0]};
        else      value = raw;
    end
endmodule

// File: rtl/pinc_lsu.sv
module pinc_lsu
    import pinc_pkg::*;
#(
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_store,
    input  logic              op_half,
    input  logic [1:0]        op_disp_kind,
    input  logic [XLEN-1:0]   op_imm,
    input  logic [REG_AW-1:0] op_base_idx,
    input  logic [REG_AW-1:0] op_data_idx,
    output logic [REG_AW-1:0] rf_base_raddr,
    input  logic [XLEN-1:0]   rf_base_rdata,
    output logic [REG_AW-1:0] rf_data_raddr,
    input  logic [XLEN-1:0]   rf_data_rdata,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_half,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              err_misalign
);
    typedef struct packed {
        lsu_state_e        state;
        logic              store;
        logic              half;
        logic              same;
        logic              err;
        logic [REG_AW-1:0] base_idx;
        logic [REG_AW-1:0] data_idx;
        logic [XLEN-1:0]   addr;
        logic [XLEN-1:0]   wdata;
        logic [XLEN-1:0]   next_base;
        logic [XLEN-1:0]   load_val;
    } lsu_regs_t;

    lsu_regs_t r_d, r_q;

    logic [XLEN-1:0] disp;
    logic            misaligned;
    logic [XLEN-1:0] load_val;

    pinc_disp_ext u_disp (
        .kind (op_disp_kind),
        .imm  (op_imm),
        .disp (disp)
    );

    pinc_align_chk u_align (
        .addr_lo    (rf_base_rdata[1:0]),
        .half       (op_half),
        .misaligned (misaligned)
    );

    pinc_load_fmt u_fmt (
        .raw   (mem_rdata),
        .half  (r_q.half),
        .value (load_val)
    );

    assign rf_base_raddr = op_base_idx;
    assign rf_data_raddr = op_data_idx;

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (op_valid) begin
                    r_d.store     = op_store;
                    r_d.half      = op_half;
                    r_d.same      = !op_store && (op_base_idx == op_data_idx);
                    r_d.base_idx  = op_base_idx;
                    r_d.data_idx  = op_data_idx;
                    r_d.addr      = rf_base_rdata;
                    r_d.wdata     = rf_data_rdata;
                    r_d.next_base = rf_base_rdata + disp;
                    if (misaligned) begin
                        r_d.err   = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.load_val = load_val;
                    r_d.state    = r_q.store ? ST_WB_BASE : ST_WB_DATA;
                end
            end
            ST_WB_DATA: begin
                r_d.state = r_q.same ? ST_IDLE : ST_WB_BASE;
            end
            ST_WB_BASE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign op_ready     = (r_q.state == ST_IDLE);
    assign err_misalign = r_q.err;
    assign mem_req      = (r_q.state == ST_REQ);
    assign mem_we       = r_q.store;
    assign mem_half     = r_q.half;
    assign mem_addr     = r_q.addr;
    assign mem_wdata    = r_q.wdata;
    assign rf_we        = (r_q.state == ST_WB_DATA) || (r_q.state == ST_WB_BASE);
    assign rf_waddr     = (r_q.state == ST_WB_DATA) ? r_q.data_idx : r_q.base_idx;
    assign rf_wdata     = (r_q.state == ST_WB_DATA) ? r_q.load_val : r_q.next_base;
endmodule

// File: rtl/pinc_lsu_chk.sv
module pinc_lsu_chk
    import pinc_pkg::*;
#(
    parameter int REG_AW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic            op_ready,
    input logic            rf_we,
    input logic            mem_req,
    input logic            mem_half,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_rsp_valid,
    input logic            err_misalign
);
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R11
    AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(op_valid && op_ready)); // R1
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> !mem_req); // R8
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> !rf_we); // R8
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_misalign |-> (!mem_req && !rf_we && op_ready)); // R9
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_half) |-> (mem_addr[1:0] == 2'b00)); // R9
    AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_half) |-> !mem_addr[0]); // R9
    AST_WRITE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_we) |-> $past(mem_rsp_valid)); // R7
endmodule

bind pinc_lsu pinc_lsu_chk #(.REG_AW(REG_AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_ready      (op_ready),
    .rf_we         (rf_we),
    .mem_req       (mem_req),
    .mem_half      (mem_half),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .err_misalign  (err_misalign)
);

// File: tb/pinc_lsu_test.sv
module pinc_lsu_test;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic          op_ready;
    logic          op_store = 1'b0;
    logic          op_half = 1'b0;
    logic [1:0]    op_disp_kind = 2'd0;
    logic [31:0]   op_imm = '0;
    logic [AW-1:0] op_base_idx = '0;
    logic [AW-1:0] op_data_idx = '0;
    logic [AW-1:0] rf_base_raddr, rf_data_raddr, rf_waddr;
    logic [31:0]   rf_base_rdata, rf_data_rdata, rf_wdata;
    logic          rf_we, mem_req, mem_we, mem_half, err_misalign;
    logic [31:0]   mem_addr, mem_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [31:0]   mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pinc_lsu #(.REG_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_ready(op_ready), .op_store(op_store), .op_half(op_half),
        .op_disp_kind(op_disp_kind), .op_imm(op_imm),
        .op_base_idx(op_base_idx), .op_data_idx(op_data_idx),
        .rf_base_raddr(rf_base_raddr), .rf_base_rdata(rf_base_rdata),
        .rf_data_raddr(rf_data_raddr), .rf_data_rdata(rf_data_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
        .err_misalign(err_misalign)
    );

    // bench register file, memory model and event log
    logic [31:0]   rf [16];
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [31:0]   pre_data = '0;
    logic          log_clr = 1'b0;
    int            rsp_lat = 1;
    int            lat_cnt = 0;
    int            cyc = 0;
    int            n_req = 0, n_w = 0, n_err = 0, rsp_cyc = -1;
    logic [31:0]   req_addr, req_wdata;
    logic          req_we, req_half;
    logic [AW-1:0] w_addr [4];
    logic [31:0]   w_data [4];
    int            w_cyc [4];

    assign rf_base_rdata = rf[rf_base_raddr];
    assign rf_data_rdata = rf[rf_data_raddr];

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return (a ^ 32'hC3A5_5A3C) + {a[15:0], a[31:16]};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pre_we) rf[pre_addr] <= pre_data;
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (mem_req) begin
            mem_rdata <= memfn(mem_addr);
            if (rsp_lat <= 1) mem_rsp_valid <= 1'b1;
            else lat_cnt <= rsp_lat - 1;
        end else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            mem_rsp_valid <= (lat_cnt == 1);
        end else begin
            mem_rsp_valid <= 1'b0;
        end
        if (log_clr) begin
            n_req <= 0; n_w <= 0; n_err <= 0; rsp_cyc <= -1;
        end else begin
            if (mem_req) begin
                n_req <= n_req + 1;
                req_addr <= mem_addr; req_we <= mem_we;
                req_half <= mem_half; req_wdata <= mem_wdata;
            end
            if (rf_we) begin
                if (n_w < 4) begin
                    w_addr[n_w] <= rf_waddr; w_data[n_w] <= rf_wdata; w_cyc[n_w] <= cyc;
                end
                n_w <= n_w + 1;
            end
            if (mem_rsp_valid) rsp_cyc <= cyc;
            if (err_misalign) n_err <= n_err + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] disp_of(input logic [1:0] k, input logic [31:0] imm);
        case (k)
            2'd0:    return {{24{imm[7]}}, imm[7:0]};
            2'd1:    return {{8{imm[23]}}, imm[23:0]};
            default: return imm;
        endcase
    endfunction

    task automatic run_op(input bit st, input bit hf, input logic [1:0] kind, input logic [31:0] imm,
                          input logic [AW-1:0] bi, input logic [AW-1:0] di,
                          input logic [31:0] bv, input logic [31:0] dv, input int lat);
        logic [31:0] nb   = bv + disp_of(kind, imm);
        logic [31:0] ld   = hf ? {16'h0, memfn(bv)[15:0]} : memfn(bv);
        bit          mis  = hf ? bv[0] : (bv[1:0] != 2'b00);
        bit          same = !st && (bi == di);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = bi; pre_data = bv;
        if (di != bi) begin
            @(negedge clk);
            pre_addr = di; pre_data = dv;
        end
        @(negedge clk);
        pre_we = 1'b0; log_clr = 1'b1; rsp_lat = lat;
        @(negedge clk);
        log_clr = 1'b0;
        chk(op_ready == 1'b1, "R8 ready when idle", {31'b0, op_ready}, 32'd1);
        op_valid = 1'b1; op_store = st; op_half = hf; op_disp_kind = kind;
        op_imm = imm; op_base_idx = bi; op_data_idx = di;
        @(negedge clk);
        op_valid = 1'b0;
        if (mis) begin
            chk(err_misalign == 1'b1, "R9 error pulse", {31'b0, err_misalign}, 32'd1);
            chk(op_ready == 1'b1, "R9 ready kept", {31'b0, op_ready}, 32'd1);
        end else begin
            chk(op_ready == 1'b0, "R8 busy after accept", {31'b0, op_ready}, 32'd0);
        end
        repeat (lat + 8) @(negedge clk);
        chk(op_ready == 1'b1, "R8 ready after op", {31'b0, op_ready}, 32'd1);
        if (mis) begin
            chk(n_req == 0, "R9 no request", n_req, 0);
            chk(n_w == 0, "R9 no write", n_w, 0);
            chk(n_err == 1, "R9 one error pulse", n_err, 1);
            chk(rf[bi] == bv, "R9 base untouched", rf[bi], bv);
            chk(rf[di] == dv, "R9 data untouched", rf[di], dv);
            return;
        end
        chk(n_err == 0, "R9 no error when aligned", n_err, 0);
        chk(n_req == 1, "R11 one request", n_req, 1);
        chk(req_addr == bv, "R1 address is old base", req_addr, bv);
        chk(req_we == st, "R1 direction", {31'b0, req_we}, {31'b0, st});
        chk(req_half == hf, "R1 size", {31'b0, req_half}, {31'b0, hf});
        chk(w_cyc[0] == rsp_cyc + 1, "R7 first write after response", w_cyc[0], rsp_cyc + 1);
        if (st) begin
            chk(req_wdata == dv, "R5 store data", req_wdata, dv);
            chk(n_w == 1, "R5 only base written", n_w, 1);
            chk(w_addr[0] == bi, "R5 write target is base", {28'b0, w_addr[0]}, {28'b0, bi});
            chk(w_data[0] == nb, "R2 R3 base update", w_data[0], nb);
        end else if (same) begin
            chk(n_w == 1, "R6 single write", n_w, 1);
            chk(w_data[0] == ld, "R6 loaded value wins", w_data[0], ld);
            chk(rf[bi] == ld, "R6 register holds load", rf[bi], ld);
        end else begin
            chk(n_w == 2, "R7 two writes", n_w, 2);
            chk(w_addr[0] == di, "R7 data written first", {28'b0, w_addr[0]}, {28'b0, di});
            chk(w_data[0] == ld, "R4 load value", w_data[0], ld);
            chk(w_addr[1] == bi, "R7 base written second", {28'b0, w_addr[1]}, {28'b0, bi});
            chk(w_cyc[1] == w_cyc[0] + 1, "R7 back-to-back writes", w_cyc[1], w_cyc[0] + 1);
            chk(w_data[1] == nb, "R2 R3 base update", w_data[1], nb);
        end
    endtask

    task automatic t_reset();
        chk(op_ready == 1'b1, "R10 ready", {31'b0, op_ready}, 32'd1);
        chk(mem_req == 1'b0, "R10 no request", {31'b0, mem_req}, 32'd0);
        chk(rf_we == 1'b0, "R10 no write", {31'b0, rf_we}, 32'd0);
        chk(err_misalign == 1'b0, "R10 no error", {31'b0, err_misalign}, 32'd0);
    endtask

    // R4 R3: word load, negative 8-bit step
    task automatic t_word_load_neg8();
        run_op(1'b0, 1'b0, 2'd0, 32'h0000_00FC, 4'd3, 4'd5, 32'h0000_1000, 32'h0, 1);
    endtask
    // R4 R3: halfword load, zero-extended, negative 24-bit step, byte 3 ignored
    task automatic t_half_load_neg24();
        run_op(1'b0, 1'b1, 2'd1, 32'hAB80_0000, 4'd6, 4'd7, 32'h2000_0002, 32'h0, 2);
    endtask
    // R5 R3: word store with full 32-bit step
    task automatic t_word_store_32();
        run_op(1'b1, 1'b0, 2'd2, 32'h1234_5678, 4'd1, 4'd2, 32'h0000_0100, 32'hDEAD_BEEF, 3);
    endtask
    // R5 R3: halfword store, positive 8-bit step, upper bytes ignored
    task automatic t_half_store_pos8();
        run_op(1'b1, 1'b1, 2'd0, 32'h5A5A_5A7F, 4'd8, 4'd9, 32'h0000_3006, 32'hCAFE_1234, 1);
    endtask
    // R6: load into its own base register
    task automatic t_same_reg_load();
        run_op(1'b0, 1'b0, 2'd0, 32'h0000_0004, 4'd10, 4'd10, 32'h0000_4000, 32'h0, 2);
    endtask
    // R9: misaligned word and halfword
    task automatic t_misaligned();
        run_op(1'b0, 1'b0, 2'd0, 32'h0000_0004, 4'd11, 4'd12, 32'h0000_5002, 32'h1111_2222, 1);
        run_op(1'b1, 1'b1, 2'd3, 32'h0000_0010, 4'd11, 4'd12, 32'h0000_5003, 32'h3333_4444, 1);
    endtask
    // R2 R7: long latency, base wraps through zero, kind 1 positive
    task automatic t_long_wrap();
        run_op(1'b0, 1'b0, 2'd1, 32'h0000_0010, 4'd13, 4'd14, 32'hFFFF_FFF8, 32'h0, 6);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_load_neg8();
        t_half_load_neg24();
        t_word_store_32();
        t_half_store_pos8();
        t_same_reg_load();
        t_misaligned();
        t_long_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule